// File: doc/BRIEF.md
# Graphics Mask and Color Register Loader

This unit sits on the device side of a synchronous graphics memory. It watches the command strobes on every clock. When all four strobes are low and the special-function select is high, it treats the cycle as a special register load. It then captures the data bus into a write-mask register, a color register, or both. Downstream write-per-bit and block-write datapaths use these two registers. Those datapaths are not part of this unit.

Two address bits choose what is loaded:
- Address bit 5 alone loads the mask from the data present in the command cycle.
- Address bit 6 alone loads the color from the data present in the command cycle.
- Both bits together load the mask from the command cycle and the color from the following cycle. During that following cycle `busy` is high and the strobes are not treated as a command.

Unlike a normal mode-register set, this load may arrive while banks are open. The data bus must, however, be idle. A load attempted while the bus is in use is refused: both registers are left alone and `err` pulses for one cycle.

Top module: `gfx_reg_loader`

## Requirements
- R1: A load is recognised only when `cs_n`, `ras_n`, `cas_n` and `we_n` are all low and `sf_sel` is high in the same cycle. Any other strobe pattern with `sf_sel` high changes neither register.
- R2: A recognised load with `a5` high and `a6` low copies `dq_in` of the command cycle into `mask_reg`. The new value is visible after that clock edge, and `color_reg` is unchanged.
- R3: A recognised load with `a6` high and `a5` low copies `dq_in` of the command cycle into `color_reg`. The new value is visible after that clock edge, and `mask_reg` is unchanged.
- R4: A recognised load with both `a5` and `a6` high performs two captures. `mask_reg` takes `dq_in` of the command cycle. `color_reg` takes `dq_in` of the next cycle. `busy` is high for exactly that next cycle.
- R5: After a single-register load, `busy` stays low, so a new command is accepted on the very next clock.
- R6: With `sf_sel` low, no strobe pattern changes either register.
- R7: A recognised load with `a5` or `a6` high while `dq_idle` is low leaves both registers unchanged. It raises `err` for exactly the following cycle and does not raise `busy`.
- R8: Synchronous reset sets `mask_reg` to all ones (no bit masked), `color_reg` to zero, and `busy` and `err` to low.
- R9: In the color data cycle (`busy` high), the strobes, `sf_sel`, the address bits and `dq_idle` are ignored as a command. `mask_reg` is unchanged, `err` stays low, and `color_reg` takes `dq_in`.
- R10: A recognised load with both `a5` and `a6` low changes no register and raises neither `busy` nor `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| sf_sel | input | 1 | Special-function select, high for graphics commands |
| a5 | input | 1 | Address bit 5, selects mask load |
| a6 | input | 1 | Address bit 6, selects color load |
| dq_in | input | DATA_W | Data bus from the pins |
| dq_idle | input | 1 | High when the data bus carries no other transfer |
| mask_reg | output | DATA_W | Write-per-bit mask register |
| color_reg | output | DATA_W | Block-write color register |
| busy | output | 1 | High during the color data cycle of a dual load |
| err | output | 1 | One-cycle pulse after a refused load |

## Verification
The bench builds the block with its defaults: a 32-bit data bus cut into 8-bit lanes. This gives four generated lanes in each register, so a lane-slicing error appears as a wrong byte rather than being hidden by a single lane. Random stimulus is biased toward the load pattern, with `dq_idle` and the address bits drawn freely. This reaches back-to-back loads, refused loads and commands landing inside the color data cycle. Directed sequences cover reset values and each address combination.

// File: rtl/gfx_ldr_pkg.sv
package gfx_ldr_pkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'b00,
    SEL_MASK  = 2'b01,
    SEL_COLOR = 2'b10,
    SEL_BOTH  = 2'b11
  } sel_e;

  typedef struct packed {
    logic ld_mask;
    logic ld_color;
    logic start_pair;
    logic reject;
  } dec_t;

endpackage

// File: rtl/gfx_ldr_decode.sv
module gfx_ldr_decode
  import gfx_ldr_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic sf_sel,
  input  logic a5,
  input  logic a6,
  input  logic dq_idle,
  input  logic busy,
  output dec_t dec
);

  logic strobes_low;
  logic live;
  sel_e sel;

  assign strobes_low = ~cs_n & ~ras_n & ~cas_n & ~we_n;
  assign live        = strobes_low & sf_sel & ~busy;
  assign sel         = sel_e'({a6, a5});

  always_comb begin
    dec = '0;
    if (live) begin
      unique case (sel)
        SEL_NONE: dec = '0;
        SEL_MASK: begin
          dec.ld_mask = dq_idle;
          dec.reject  = ~dq_idle;
        end
        SEL_COLOR: begin
          dec.ld_color = dq_idle;
          dec.reject   = ~dq_idle;
        end
        SEL_BOTH: begin
          dec.ld_mask    = dq_idle;
          dec.start_pair = dq_idle;
          dec.reject     = ~dq_idle;
        end
        default: dec = '0;
      endcase
    end
  end

endmodule

// File: rtl/gfx_ldr_seq.sv
module gfx_ldr_seq
  import gfx_ldr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  dec_t dec,
  output logic busy,
  output logic err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      err  <= 1'b0;
    end else begin
      busy <= dec.start_pair;
      err  <= dec.reject;
    end
  end

endmodule

// File: rtl/gfx_ldr_regbank.sv
module gfx_ldr_regbank #(
  parameter int          DATA_W  = 32,
  parameter int          LANE_W  = 8,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);

  localparam int LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        q[l*LANE_W +: LANE_W] <= RST_VAL[l*LANE_W +: LANE_W];
      end else if (wr) begin
        q[l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
      end
    end
  end

endmodule

// File: rtl/gfx_reg_loader.sv
module gfx_reg_loader
  import gfx_ldr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              sf_sel,
  input  logic              a5,
  input  logic              a6,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              dq_idle,
  output logic [DATA_W-1:0] mask_reg,
  output logic [DATA_W-1:0] color_reg,
  output logic              busy,
  output logic              err
);

  localparam logic [DATA_W-1:0] MASK_RST  = '1;
  localparam logic [DATA_W-1:0] COLOR_RST = '0;

  dec_t dec;
  logic color_wr;

  gfx_ldr_decode u_dec (
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .sf_sel  (sf_sel),
    .a5      (a5),
    .a6      (a6),
    .dq_idle (dq_idle),
    .busy    (busy),
    .dec     (dec)
  );

  gfx_ldr_seq u_seq (
    .clk  (clk),
    .rst  (rst),
    .dec  (dec),
    .busy (busy),
    .err  (err)
  );

  assign color_wr = dec.ld_color | busy;

  gfx_ldr_regbank #(
    .DATA_W  (DATA_W),
    .LANE_W  (LANE_W),
    .RST_VAL (MASK_RST)
  ) u_mask (
    .clk (clk),
    .rst (rst),
    .wr  (dec.ld_mask),
    .din (dq_in),
    .q   (mask_reg)
  );

  gfx_ldr_regbank #(
    .DATA_W  (DATA_W),
    .LANE_W  (LANE_W),
    .RST_VAL (COLOR_RST)
  ) u_color (
    .clk (clk),
    .rst (rst),
    .wr  (color_wr),
    .din (dq_in),
    .q   (color_reg)
  );

endmodule

// File: rtl/gfx_reg_loader_chk.sv
module gfx_reg_loader_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              sf_sel,
  input logic              a5,
  input logic              a6,
  input logic [DATA_W-1:0] dq_in,
  input logic              dq_idle,
  input logic [DATA_W-1:0] mask_reg,
  input logic [DATA_W-1:0] color_reg,
  input logic              busy,
  input logic              err
);

  logic cmd;
  assign cmd = !cs_n && !ras_n && !cas_n && !we_n && sf_sel && !busy;

  p_reset_vals_r8: assert property (@(posedge clk)
    $past(rst) && !rst |-> (mask_reg == '1) && (color_reg == '0) && !busy && !err);

  p_mask_load_r2: assert property (@(posedge clk) disable iff (rst)
    cmd && a5 && dq_idle |=> mask_reg == $past(dq_in));

  p_color_load_r3: assert property (@(posedge clk) disable iff (rst)
    cmd && a6 && !a5 && dq_idle |=> color_reg == $past(dq_in));

  p_pair_second_r4: assert property (@(posedge clk) disable iff (rst)
    busy |=> color_reg == $past(dq_in) && !busy);

  p_pair_start_r4: assert property (@(posedge clk) disable iff (rst)
    cmd && a5 && a6 && dq_idle |=> busy);

  p_single_free_r5: assert property (@(posedge clk) disable iff (rst)
    cmd && (a5 ^ a6) |=> !busy);

  p_mask_guard_r6: assert property (@(posedge clk) disable iff (rst)
    !(cmd && a5 && dq_idle) |=> $stable(mask_reg));

  p_refuse_r7: assert property (@(posedge clk) disable iff (rst)
    cmd && (a5 || a6) && !dq_idle |=> err && !busy && $stable(mask_reg) && $stable(color_reg));

  p_err_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    err |=> !err || $past(cmd && !dq_idle && (a5 || a6)));

  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> !err);

endmodule

bind gfx_reg_loader gfx_reg_loader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .sf_sel    (sf_sel),
  .a5        (a5),
  .a6        (a6),
  .dq_in     (dq_in),
  .dq_idle   (dq_idle),
  .mask_reg  (mask_reg),
  .color_reg (color_reg),
  .busy      (busy),
  .err       (err)
);

// File: tb/gfx_reg_loader_bench.sv
module gfx_reg_loader_bench;

  localparam int DATA_W = 32;
  localparam int LANE_W = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic              cs_n, ras_n, cas_n, we_n, sf_sel, a5, a6, dq_idle;
  logic [DATA_W-1:0] dq_in;
  logic [DATA_W-1:0] mask_reg, color_reg;
  logic              busy, err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [DATA_W-1:0] e_mask, e_color;
  logic              e_busy, e_err;

  always #5 clk = ~clk;

  gfx_reg_loader #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_gfx_reg_loader (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .sf_sel(sf_sel), .a5(a5), .a6(a6), .dq_in(dq_in), .dq_idle(dq_idle),
    .mask_reg(mask_reg), .color_reg(color_reg), .busy(busy), .err(err)
  );

  function automatic bit is_load(logic c, logic r, logic ca, logic w, logic s);
    return !c && !r && !ca && !w && s;
  endfunction

  task automatic chk(string req, logic [DATA_W-1:0] got, logic [DATA_W-1:0] exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic compare(string req);
    chk(req, mask_reg, e_mask, "mask_reg");
    chk(req, color_reg, e_color, "color_reg");
    chk(req, {{(DATA_W-1){1'b0}}, busy}, {{(DATA_W-1){1'b0}}, e_busy}, "busy");
    chk(req, {{(DATA_W-1){1'b0}}, err},  {{(DATA_W-1){1'b0}}, e_err},  "err");
  endtask

  // drive at negedge, model at posedge, compare at the following negedge
  task automatic cyc(string req, logic [4:0] strb, logic sa5, logic sa6,
                     logic idle, logic [DATA_W-1:0] d);
    {cs_n, ras_n, cas_n, we_n, sf_sel} = strb;
    a5 = sa5; a6 = sa6; dq_idle = idle; dq_in = d;
    @(posedge clk);
    e_err = 1'b0;
    if (e_busy) begin
      e_color = d;
      e_busy  = 1'b0;
    end else if (is_load(strb[4], strb[3], strb[2], strb[1], strb[0]) && (sa5 || sa6)) begin
      if (!idle) e_err = 1'b1;
      else begin
        if (sa5) e_mask = d;
        if (sa6 && !sa5) e_color = d;
        if (sa5 && sa6) e_busy = 1'b1;
      end
    end
    @(negedge clk);
    compare(req);
  endtask

  localparam logic [4:0] LOAD = 5'b00001;
  localparam logic [4:0] NOP  = 5'b01110;
  localparam logic [4:0] PLAIN = 5'b00000;

  initial begin
    automatic int unsigned seed = $urandom(32'd1234);
    rst = 1'b1;
    {cs_n, ras_n, cas_n, we_n, sf_sel} = NOP;
    a5 = 0; a6 = 0; dq_idle = 1; dq_in = '0;
    e_mask = '1; e_color = '0; e_busy = 0; e_err = 0;
    repeat (3) @(negedge clk);
    compare("R8");
    rst = 1'b0;

    cyc("R2", LOAD, 1, 0, 1, 32'hA5A5_0F0F);
    cyc("R5", LOAD, 0, 1, 1, 32'h1234_5678);
    cyc("R3", LOAD, 0, 1, 1, 32'hCAFE_BEEF);
    cyc("R4", LOAD, 1, 1, 1, 32'h0000_FFFF);
    cyc("R4", NOP,  0, 0, 1, 32'h8765_4321);
    cyc("R4", LOAD, 1, 1, 1, 32'h1111_2222);
    cyc("R9", LOAD, 1, 0, 0, 32'h3333_4444);
    cyc("R6", PLAIN, 1, 1, 1, 32'hDEAD_DEAD);
    cyc("R1", 5'b10001, 1, 1, 1, 32'h5555_5555);
    cyc("R1", 5'b00011, 1, 0, 1, 32'h6666_6666);
    cyc("R7", LOAD, 1, 1, 0, 32'h7777_7777);
    cyc("R7", NOP,  0, 0, 1, 32'h0);
    cyc("R10", LOAD, 0, 0, 1, 32'h9999_9999);
    cyc("R10", LOAD, 0, 0, 0, 32'h9999_9999);

    for (int i = 0; i < 3000; i++) begin
      automatic logic [4:0] s = ($urandom % 3 != 0) ? LOAD : 5'($urandom);
      cyc("rand", s, 1'($urandom), 1'($urandom), ($urandom % 4 != 0), $urandom);
    end

    rst = 1'b1;
    @(posedge clk);
    e_mask = '1; e_color = '0; e_busy = 0; e_err = 0;
    @(negedge clk);
    compare("R8");
    rst = 1'b0;
    if (seed == 0) seed = 1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule